// File: doc/BRIEF.md
# Core Wait-State Clock Controller

This block puts a processor core into a low-power standby state and brings it back out. When the instruction decoder raises a wait request, the controller turns off the clock enables for the core and for the on-chip memories. The oscillator enable and every peripheral clock enable stay on. A bus request keeps being granted while the core is idle. The core stays asleep until one of two things happens: an interrupt that is not masked, or an external hardware reset.

Wake-up on an interrupt happens only at a clock edge where the cycle-phase indicator marks the second phase. Because of this, several cores that share one interrupt line all resume in the same cycle. On the wake edge the controller releases the enables and emits a one-cycle strobe that starts exception processing. A second output says whether reset or an interrupt caused the wake.

A wait request can arrive while an unmasked interrupt is already pending. In that case the core is never put to sleep. Instead the controller marks a few no-op slots and then starts exception processing after a fixed minimum latency. A wait request raised inside a fast-interrupt or repeat context is refused and reported as illegal.

Top module: `wait_clk_ctrl`

## Requirements
- R1: A wait request seen in the running state, with no fast or repeat context and no unmasked interrupt pending, drives `core_clk_en` and `mem_clk_en` low and `waiting` high from the next cycle.
- R2: `osc_en` and every bit of `periph_clk_en` stay 1 in every state, including the wait state.
- R3: An `irq_mask` bit of 1 masks the matching `irq_pend` bit. A masked pending interrupt never ends the wait state, and a wait request seen while already waiting has no effect.
- R4: An unmasked pending interrupt ends the wait state only at a clock edge where `phase_t2` is 1. After that edge, `waiting` is 0, both core enables are 1, `wake_stb` is 1 for exactly one cycle, and `wake_by_rst` is 0.
- R5: `ext_rst` at a clock edge, in any state, gives all enables 1 and `waiting` 0 on the next cycle, with `wake_stb` = 1 and `wake_by_rst` = 1. It takes priority over an interrupt wake at the same edge.
- R6: A wait request with an unmasked interrupt pending never enters the wait state. The core enables stay 1, and `nop_slot` is 1 for the first NOP_SLOTS cycles after the request edge.
- R7: In the case of R6, `wake_stb` (with `wake_by_rst` = 0) is 1 in the cycle exactly MIN_CYCLES cycles after the request edge, and not before.
- R8: `bus_grant` repeats `bus_req` one cycle later, whether the core is running or waiting.
- R9: A wait request seen while `fast_ctx` or `rep_ctx` is 1 pulses `illegal_stb` for one cycle. It neither enters the wait state nor produces no-op slots.
- R10: Asserting `rst_n` low puts the block into the running state at once. All enables are 1, and `waiting`, `wake_stb`, `illegal_stb`, `nop_slot` and `bus_grant` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wait_req | input | 1 | Decoded wait instruction |
| fast_ctx | input | 1 | Core is in a fast-interrupt routine |
| rep_ctx | input | 1 | Core is repeating the current instruction |
| irq_pend | input | IRQ_W | Pending interrupt lines |
| irq_mask | input | IRQ_W | Mask per line, 1 = masked |
| phase_t2 | input | 1 | 1 when the current cycle is the second phase |
| ext_rst | input | 1 | External hardware reset request, synchronous |
| bus_req | input | 1 | External bus request |
| core_clk_en | output | 1 | Core clock enable |
| mem_clk_en | output | 1 | Internal memory clock enable |
| osc_en | output | 1 | Oscillator enable |
| periph_clk_en | output | PERIPH_W | Peripheral clock enables |
| bus_grant | output | 1 | Bus grant |
| waiting | output | 1 | Block is in the wait state |
| nop_slot | output | 1 | No-op slot marker for the collapsed wait |
| wake_stb | output | 1 | One-cycle start of exception processing |
| wake_by_rst | output | 1 | Cause of the last wake, 1 = reset |
| illegal_stb | output | 1 | Wait request refused |

## Verification
The bench builds the block with IRQ_W = 4, PERIPH_W = 3, NOP_SLOTS = 3 and MIN_CYCLES = 8. The shorter minimum latency lets the collapsed-wait window be checked cycle by cycle on both sides of the strobe. Four interrupt lines make it possible to hold one line pending but masked while another line carries the real wake. Three peripheral enables show that the all-ones check covers the whole vector, not just one bit.

// File: rtl/wait_clk_ctrl.sv
module wait_clk_ctrl #(
  parameter int IRQ_W      = 4,
  parameter int PERIPH_W   = 3,
  parameter int NOP_SLOTS  = 3,
  parameter int MIN_CYCLES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wait_req,
  input  logic                fast_ctx,
  input  logic                rep_ctx,
  input  logic [IRQ_W-1:0]    irq_pend,
  input  logic [IRQ_W-1:0]    irq_mask,
  input  logic                phase_t2,
  input  logic                ext_rst,
  input  logic                bus_req,
  output logic                core_clk_en,
  output logic                mem_clk_en,
  output logic                osc_en,
  output logic [PERIPH_W-1:0] periph_clk_en,
  output logic                bus_grant,
  output logic                waiting,
  output logic                nop_slot,
  output logic                wake_stb,
  output logic                wake_by_rst,
  output logic                illegal_stb
);
  localparam int CNT_W = $clog2(MIN_CYCLES + 1);

  typedef enum logic [1:0] {ST_RUN, ST_IDLE, ST_DRAIN} st_t;
  st_t              state;
  logic [CNT_W-1:0] cnt;
  logic             irq_live;

  assign irq_live      = |(irq_pend & ~irq_mask);
  assign waiting       = (state == ST_IDLE);
  assign core_clk_en   = !waiting;
  assign mem_clk_en    = !waiting;
  assign osc_en        = 1'b1;
  assign periph_clk_en = '1;
  assign nop_slot      = (state == ST_DRAIN) && (cnt < CNT_W'(NOP_SLOTS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_RUN;
      cnt         <= '0;
      wake_stb    <= 1'b0;
      wake_by_rst <= 1'b0;
      illegal_stb <= 1'b0;
      bus_grant   <= 1'b0;
    end else begin
      wake_stb    <= 1'b0;
      illegal_stb <= 1'b0;
      bus_grant   <= bus_req;
      if (ext_rst) begin
        state       <= ST_RUN;
        cnt         <= '0;
        wake_stb    <= 1'b1;
        wake_by_rst <= 1'b1;
      end else begin
        case (state)
          ST_RUN: if (wait_req) begin
            if (fast_ctx || rep_ctx) illegal_stb <= 1'b1;
            else if (irq_live) begin
              state <= ST_DRAIN;
              cnt   <= '0;
            end else state <= ST_IDLE;
          end
          ST_IDLE: if (irq_live && phase_t2) begin
            state       <= ST_RUN;
            wake_stb    <= 1'b1;
            wake_by_rst <= 1'b0;
          end
          ST_DRAIN: if (cnt == CNT_W'(MIN_CYCLES - 1)) begin
            state       <= ST_RUN;
            cnt         <= '0;
            wake_stb    <= 1'b1;
            wake_by_rst <= 1'b0;
          end else cnt <= cnt + 1'b1;
          default: state <= ST_RUN;
        endcase
      end
    end
  end

  assert_gated_in_wait_R1: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> (!core_clk_en && !mem_clk_en));
  assert_enter_on_request_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(waiting) |-> $past(wait_req));
  assert_masked_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !ext_rst && !irq_live) |=> waiting);
  assert_wake_on_t2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(waiting) && !$past(ext_rst)) |-> ($past(phase_t2) && wake_stb && !wake_by_rst));
  assert_single_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_stb |=> !(wake_stb && !wake_by_rst));
  assert_reset_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst |=> (wake_stb && wake_by_rst && core_clk_en && !waiting));
  assert_grant_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant == $past(bus_req));
  assert_illegal_no_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_stb |-> (!waiting && !nop_slot));
endmodule

// File: tb/tb_wait_clk_ctrl.sv
module tb_wait_clk_ctrl;
  localparam int IRQ_W = 4, PERIPH_W = 3, NOP_SLOTS = 3, MIN_CYCLES = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wait_req = 0, fast_ctx = 0, rep_ctx = 0, phase_t2 = 0, ext_rst = 0, bus_req = 0;
  logic [IRQ_W-1:0] irq_pend = '0, irq_mask = '0;
  logic core_clk_en, mem_clk_en, osc_en, bus_grant, waiting, nop_slot;
  logic wake_stb, wake_by_rst, illegal_stb;
  logic [PERIPH_W-1:0] periph_clk_en;
  int checks = 0, fails = 0;
  bit done = 0;

  wait_clk_ctrl #(.IRQ_W(IRQ_W), .PERIPH_W(PERIPH_W), .NOP_SLOTS(NOP_SLOTS),
                  .MIN_CYCLES(MIN_CYCLES)) dut (
    .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .fast_ctx(fast_ctx), .rep_ctx(rep_ctx),
    .irq_pend(irq_pend), .irq_mask(irq_mask), .phase_t2(phase_t2), .ext_rst(ext_rst),
    .bus_req(bus_req), .core_clk_en(core_clk_en), .mem_clk_en(mem_clk_en), .osc_en(osc_en),
    .periph_clk_en(periph_clk_en), .bus_grant(bus_grant), .waiting(waiting),
    .nop_slot(nop_slot), .wake_stb(wake_stb), .wake_by_rst(wake_by_rst),
    .illegal_stb(illegal_stb));

  always #10 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic always_on(input string req);
    check(req, "osc_en", osc_en, 1);
    check(req, "periph_clk_en", periph_clk_en, (1 << PERIPH_W) - 1);
  endtask

  task automatic enter_wait();
    irq_pend = '0; phase_t2 = 0;
    wait_req = 1; tick(); wait_req = 0;
  endtask

  task automatic t_reset();
    check("R10", "core_clk_en", core_clk_en, 1);
    check("R10", "mem_clk_en", mem_clk_en, 1);
    check("R10", "waiting", waiting, 0);
    check("R10", "wake_stb", wake_stb, 0);
    check("R10", "nop_slot", nop_slot, 0);
    check("R10", "bus_grant", bus_grant, 0);
    always_on("R2");
  endtask

  task automatic t_entry_masked();
    enter_wait();
    check("R1", "waiting", waiting, 1);
    check("R1", "core_clk_en", core_clk_en, 0);
    check("R1", "mem_clk_en", mem_clk_en, 0);
    always_on("R2");
    irq_pend = 4'b0010; irq_mask = 4'b0010; phase_t2 = 1;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R3", "waiting masked", waiting, 1);
      check("R3", "wake_stb masked", wake_stb, 0);
    end
    wait_req = 1; tick(); wait_req = 0;
    check("R3", "waiting after repeat request", waiting, 1);
    check("R3", "nop_slot after repeat request", nop_slot, 0);
  endtask

  task automatic t_t2_wake();
    irq_mask = 4'b0000; phase_t2 = 0;
    tick();
    check("R4", "waiting on T1", waiting, 1);
    check("R4", "wake_stb on T1", wake_stb, 0);
    phase_t2 = 1; tick();
    check("R4", "waiting after T2", waiting, 0);
    check("R4", "core_clk_en after T2", core_clk_en, 1);
    check("R4", "mem_clk_en after T2", mem_clk_en, 1);
    check("R4", "wake_stb", wake_stb, 1);
    check("R4", "wake_by_rst", wake_by_rst, 0);
    irq_pend = '0; phase_t2 = 0; tick();
    check("R4", "wake_stb width", wake_stb, 0);
  endtask

  task automatic t_reset_priority();
    enter_wait();
    irq_pend = 4'b0100; phase_t2 = 1; ext_rst = 1; tick();
    ext_rst = 0; irq_pend = '0; phase_t2 = 0;
    check("R5", "wake_stb", wake_stb, 1);
    check("R5", "wake_by_rst", wake_by_rst, 1);
    check("R5", "core_clk_en", core_clk_en, 1);
    check("R5", "waiting", waiting, 0);
    always_on("R2");
    tick();
    check("R5", "wake_stb clear", wake_stb, 0);
  endtask

  task automatic t_collapse();
    irq_pend = 4'b1000; irq_mask = '0;
    wait_req = 1; tick(); wait_req = 0;
    for (int j = 0; j <= MIN_CYCLES; j++) begin
      check("R6", $sformatf("waiting j=%0d", j), waiting, 0);
      check("R6", $sformatf("core_clk_en j=%0d", j), core_clk_en, 1);
      check("R6", $sformatf("nop_slot j=%0d", j), nop_slot, (j < NOP_SLOTS) ? 1 : 0);
      check("R7", $sformatf("wake_stb j=%0d", j), wake_stb, (j == MIN_CYCLES) ? 1 : 0);
      if (j == MIN_CYCLES) check("R7", "wake_by_rst", wake_by_rst, 0);
      if (j < MIN_CYCLES) tick();
    end
    irq_pend = '0; tick();
    check("R7", "wake_stb after", wake_stb, 0);
  endtask

  task automatic t_illegal();
    fast_ctx = 1; wait_req = 1; tick(); wait_req = 0; fast_ctx = 0;
    check("R9", "illegal_stb fast", illegal_stb, 1);
    check("R9", "waiting fast", waiting, 0);
    check("R9", "nop_slot fast", nop_slot, 0);
    tick();
    check("R9", "illegal_stb width", illegal_stb, 0);
    check("R9", "waiting later", waiting, 0);
    irq_pend = 4'b0001; rep_ctx = 1; wait_req = 1; tick(); wait_req = 0; rep_ctx = 0;
    check("R9", "illegal_stb rep", illegal_stb, 1);
    check("R9", "nop_slot rep", nop_slot, 0);
    irq_pend = '0; tick();
    check("R9", "no wake after rep", wake_stb, 0);
  endtask

  task automatic t_bus();
    bus_req = 1; tick();
    check("R8", "bus_grant running", bus_grant, 1);
    enter_wait();
    check("R8", "bus_grant waiting", bus_grant, 1);
    bus_req = 0; tick();
    check("R8", "bus_grant drop waiting", bus_grant, 0);
    bus_req = 1; tick();
    check("R8", "bus_grant raise waiting", bus_grant, 1);
    check("R8", "still waiting", waiting, 1);
  endtask

  task automatic t_async_reset();
    rst_n = 0; #2;
    check("R10", "core_clk_en async", core_clk_en, 1);
    check("R10", "waiting async", waiting, 0);
    check("R10", "bus_grant async", bus_grant, 0);
    bus_req = 0;
    tick(); rst_n = 1; tick();
    check("R10", "running after release", core_clk_en, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1; tick();
    t_reset();
    t_entry_masked();
    t_t2_wake();
    t_reset_priority();
    t_collapse();
    t_illegal();
    t_bus();
    t_async_reset();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule